// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer that software services by writing a control word. The word holds a restart count, a run/stop command and a 7-bit key. Once the watchdog is running, a write is only honoured when its key is the bitwise inverse of the key from the last honoured write. A write whose key does not match leaves the block exactly as it was. Because the required key flips on every service, a runaway loop that keeps writing one constant value cannot keep the watchdog alive.

The down-counter advances only on cycles where a slow tick-enable strobe is high, nominally near 760 Hz. Expiry happens in two stages. The first expiry raises a non-maskable interrupt and reloads a one-tick grace count. If no honoured write arrives before that grace count runs out, the block emits a single-cycle reset-request pulse and the counter stops. The bus decoder sits in front of this block and the reset controller sits behind it; neither is part of it.

The control word is 16 bits wide:

| Bits | Field |
|------|-------|
| [7:0] | Restart count |
| [8] | Run command |
| [15:9] | Key |

Top module: `keyed_watchdog`

## Requirements
- R1: After a synchronous active-low reset, `nmi_o` and `reset_req_o` are low, the counter is stopped, and the stored run bit and key are cleared. Ticks then cause no expiry.
- R2: The control word decodes as restart count in bits [7:0], run command in bit 8 and key in bits [15:9]. An honoured write loads the counter with the count and stores the run bit and key. If bit 8 is 1, the counter runs. If bit 8 is 0, the counter stops.
- R3: While the counter runs, each tick-enable cycle lowers it by one. Loading a count N and then applying N ticks raises `nmi_o` in the cycle after the N-th tick.
- R4: A count field of zero loads 256, so the first expiry comes on the 256th tick and not before.
- R5: While the stored run bit is 1, a write whose key is not the bitwise inverse of the stored key is ignored. The count, the run state, the key and the expiry history all stay unchanged.
- R6: While the stored run bit is 0, a write with any key is honoured, and its key becomes the reference for the next write.
- R7: After the first expiry, the counter reloads a grace count of one tick. The next tick with no honoured write in between drives `reset_req_o` high for exactly one cycle and stops the counter. `nmi_o` stays high, and later ticks cause no further pulses.
- R8: An honoured write lowers `nmi_o` in the following cycle and clears the expiry history. The next expiry after it raises `nmi_o` again and does not request a reset.
- R9: After an honoured write with run command 0, no number of ticks raises `nmi_o` or `reset_req_o`.
- R10: When an honoured write and a tick arrive in the same cycle, the write wins. The counter takes the new count and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | One-cycle strobe: the control word on `wr_data_i` is written |
| wr_data_i | input | 16 | Control word: count [7:0], run [8], key [15:9] |
| tick_en_i | input | 1 | Slow tick strobe, high for one cycle per tick |
| nmi_o | output | 1 | Non-maskable interrupt, raised on the first expiry |
| reset_req_o | output | 1 | One-cycle reset-request pulse on the second expiry |

## Verification
The embedded properties assume that `wr_en_i` and `tick_en_i` are plain single-cycle strobes. They also assume that a reload value is never zero, because the zero-means-256 mapping and the one-tick grace count guarantee it. The stimulus drives each input once per cycle on the falling edge. Random write words sometimes carry the correct inverted key and sometimes a wrong one. Counts are kept small so that both expiry stages, and coincident write-and-tick cycles, occur often. Directed cases cover the full 256-tick count, a write while stopped, and servicing after the warning interrupt.

// File: rtl/wdg_pkg.sv
// Package for the keyed watchdog.
// Holds the expiry-stage encoding shared by the counter and the expiry controller.
package wdg_pkg;
    // ARMED: no expiry since the last honoured write.
    // WARNED: the interrupt has been raised and the grace count is running.
    typedef enum logic {
        STG_ARMED  = 1'b0,
        STG_WARNED = 1'b1
    } wdg_stage_e;
endpackage

// File: rtl/wdg_key_gate.sv
// Key gate for the watchdog control word.
// Decides whether a write is honoured and keeps the stored run bit and key.
// Assumes wr_en_i is a one-cycle strobe.
// Only the run bit and key are stored, because no other stored field changes behaviour.
module wdg_key_gate #(
    parameter int CNT_W = 8,
    parameter int KEY_W = 7,
    localparam int RUN_BIT = CNT_W,
    localparam int KEY_LSB = CNT_W + 1,
    localparam int WORD_W  = CNT_W + 1 + KEY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic              accept_o
);
    logic             run_q;
    logic [KEY_W-1:0] key_q;
    logic [KEY_W-1:0] new_key;
    logic             key_ok;

    // Pick out the key field and compare it with the inverse of the stored key.
    always_comb begin
        new_key  = wr_data_i[KEY_LSB +: KEY_W];
        key_ok   = (new_key == ~key_q);
        accept_o = wr_en_i && (!run_q || key_ok);
    end

    // Store the run bit and key of every honoured write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            key_q <= '0;
        end else if (accept_o) begin
            run_q <= wr_data_i[RUN_BIT];
            key_q <= new_key;
        end
    end

    // R5: a write with a wrong key while running leaves the stored state unchanged.
    assert_bad_key_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && run_q && (wr_data_i[KEY_LSB +: KEY_W] != ~key_q))
        |=> ($stable(key_q) && $stable(run_q)));

    // R6: while stopped, any write becomes the new reference.
    assert_open_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !run_q) |=> (key_q == $past(wr_data_i[KEY_LSB +: KEY_W])));
endmodule

// File: rtl/wdg_counter.sv
// Tick-driven down-counter for the watchdog.
// An honoured write loads the count; a zero count field means 2**CNT_W.
// On expiry the counter either reloads the grace count or, when halt_i is set, stops.
// Assumes GRACE_TICKS >= 1.
module wdg_counter #(
    parameter int CNT_W = 8,
    parameter int GRACE_TICKS = 1,
    localparam int CW = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_cnt_i,
    input  logic             run_cmd_i,
    input  logic             tick_i,
    input  logic             halt_i,
    output logic             expire_o
);
    logic [CW-1:0] count_q;
    logic          run_q;
    logic [CW-1:0] load_val;

    // Map a zero count field to the full range, and detect the last tick.
    always_comb begin
        load_val = (load_cnt_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, load_cnt_i};
        expire_o = run_q && tick_i && !load_i && (count_q <= CW'(1));
    end

    // Load on a write; otherwise count down, reload the grace count, or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else if (load_i) begin
            count_q <= load_val;
            run_q   <= run_cmd_i;
        end else if (tick_i && run_q) begin
            if (count_q <= CW'(1)) begin
                if (halt_i) run_q   <= 1'b0;
                else        count_q <= CW'(GRACE_TICKS);
            end else begin
                count_q <= count_q - CW'(1);
            end
        end
    end

    // R3: every tick while running, with no write, lowers the count by one.
    assert_tick_decrements_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_i && !load_i && (count_q > CW'(1)))
        |=> (count_q == $past(count_q) - CW'(1)));

    // R4: a zero count field loads the full range.
    assert_zero_is_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (load_cnt_i == '0)) |=> (count_q == CW'(1 << CNT_W)));

    // R9: a stopped counter never expires.
    assert_no_expire_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q) |-> !expire_o);
endmodule

// File: rtl/wdg_expiry_ctl.sv
// Two-stage expiry controller.
// The first expiry raises the interrupt; a later expiry with no honoured write in between
// pulses the reset request for one cycle.
// Assumes the counter drops expire_i whenever a write loads it.
module wdg_expiry_ctl
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic expire_i,
    output logic halt_o,
    output logic nmi_o,
    output logic reset_req_o
);
    wdg_stage_e stage_q;
    logic       nmi_q;
    logic       rr_q;

    // Step through the expiry stages; an honoured write clears the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= STG_ARMED;
            nmi_q   <= 1'b0;
            rr_q    <= 1'b0;
        end else if (accept_i) begin
            stage_q <= STG_ARMED;
            nmi_q   <= 1'b0;
            rr_q    <= 1'b0;
        end else if (expire_i) begin
            if (stage_q == STG_ARMED) begin
                stage_q <= STG_WARNED;
                nmi_q   <= 1'b1;
                rr_q    <= 1'b0;
            end else begin
                rr_q    <= 1'b1;
            end
        end else begin
            rr_q <= 1'b0;
        end
    end

    // Drive the outputs from the registered state.
    always_comb begin
        halt_o      = (stage_q == STG_WARNED);
        nmi_o       = nmi_q;
        reset_req_o = rr_q;
    end

    // R7: the reset request lasts exactly one cycle.
    assert_reset_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |=> !reset_req_o);

    // R7: a reset request is always preceded by the interrupt.
    assert_reset_after_nmi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> nmi_o);

    // R8: an honoured write lowers both outputs.
    assert_service_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> (!nmi_o && !reset_req_o));
endmodule

// File: rtl/keyed_watchdog.sv
// Keyed watchdog with two-stage expiry.
// Joins the key gate, the tick counter and the expiry controller.
// Assumes wr_en_i and tick_en_i are single-cycle strobes in the clk domain.
module keyed_watchdog #(
    parameter int CNT_W = 8,
    parameter int KEY_W = 7,
    parameter int GRACE_TICKS = 1,
    localparam int WORD_W = CNT_W + 1 + KEY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              tick_en_i,
    output logic              nmi_o,
    output logic              reset_req_o
);
    logic accept;
    logic expire;
    logic halt;

    wdg_key_gate #(.CNT_W(CNT_W), .KEY_W(KEY_W)) i_gate (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .accept_o(accept)
    );

    wdg_counter #(.CNT_W(CNT_W), .GRACE_TICKS(GRACE_TICKS)) i_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .load_cnt_i(wr_data_i[CNT_W-1:0]),
        .run_cmd_i(wr_data_i[CNT_W]), .tick_i(tick_en_i), .halt_i(halt),
        .expire_o(expire)
    );

    wdg_expiry_ctl i_ctl (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .expire_i(expire),
        .halt_o(halt), .nmi_o(nmi_o), .reset_req_o(reset_req_o)
    );
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        tick = 1'b0;
    logic        nmi;
    logic        rr;

    int checks = 0;
    int fails  = 0;

    // Bench-side expected state, built from the requirements.
    bit       m_run;
    bit [6:0] m_key;
    int       m_cnt;
    bit       m_go;
    bit       m_hit;
    bit       m_nmi;
    bit       m_rr;

    always #5 clk = ~clk;

    keyed_watchdog i_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .tick_en_i(tick), .nmi_o(nmi), .reset_req_o(rr)
    );

    function automatic logic [15:0] word(input bit [6:0] k, input bit run, input bit [7:0] c);
        return {k, run, c};
    endfunction

    function automatic void model_reset();
        m_run = 0; m_key = '0; m_cnt = 0; m_go = 0; m_hit = 0; m_nmi = 0; m_rr = 0;
    endfunction

    function automatic void model_step(input bit we, input logic [15:0] d, input bit tk);
        bit ok;
        ok = we && (!m_run || d[15:9] == ~m_key);
        m_rr = 0;
        if (ok) begin
            m_run = d[8]; m_key = d[15:9];
            m_cnt = (d[7:0] == 0) ? 256 : int'(d[7:0]);
            m_go = d[8]; m_hit = 0; m_nmi = 0;
        end else if (tk && m_go) begin
            if (m_cnt <= 1) begin
                if (!m_hit) begin m_hit = 1; m_nmi = 1; m_cnt = 1; end
                else begin m_rr = 1; m_go = 0; end
            end else m_cnt--;
        end
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic step(input bit we, input logic [15:0] d, input bit tk);
        wr_en = we; wr_data = d; tick = tk;
        @(posedge clk);
        model_step(we, d, tk);
        @(negedge clk);
        wr_en = 0; tick = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        // R1: outputs low after reset, ticks do nothing
        check(nmi, 0, "R1 nmi after reset");
        check(rr, 0, "R1 reset_req after reset");
        ticks(5);
        check(nmi, 0, "R1 no expiry while stopped");

        // R2 R3 R6 R7: count 3, any key accepted while stopped
        step(1, word(7'h15, 1, 8'd3), 0);
        ticks(2);
        check(nmi, 0, "R3 nmi before 3rd tick");
        ticks(1);
        check(nmi, 1, "R3 nmi after 3rd tick");
        check(rr, 0, "R7 no reset on first expiry");
        ticks(1);
        check(rr, 1, "R7 reset after grace tick");
        step(0, '0, 0);
        check(rr, 0, "R7 reset is one cycle");
        ticks(4);
        check(rr, 0, "R7 counter stopped after reset request");
        check(nmi, 1, "R7 nmi held");

        // R4: zero count means 256
        do_reset();
        step(1, word(7'h2A, 1, 8'd0), 0);
        ticks(255);
        check(nmi, 0, "R4 no expiry at 255");
        ticks(1);
        check(nmi, 1, "R4 expiry at 256");

        // R5 R8: wrong key ignored, correct key services
        do_reset();
        step(1, word(7'h11, 1, 8'd4), 0);
        ticks(2);
        step(1, word(7'h11, 1, 8'd50), 0);
        ticks(2);
        check(nmi, 1, "R5 wrong key ignored");
        step(1, word(7'h6E, 1, 8'd5), 0);
        check(nmi, 0, "R8 service lowers nmi");
        ticks(4);
        check(nmi, 0, "R8 reload honoured");
        ticks(1);
        check(nmi, 1, "R8 fresh first expiry");
        check(rr, 0, "R8 history cleared");

        // R9 R6: stop command, then any key accepted
        do_reset();
        step(1, word(7'h40, 0, 8'd2), 0);
        ticks(10);
        check(nmi, 0, "R9 stopped counter no nmi");
        check(rr, 0, "R9 stopped counter no reset");
        step(1, word(7'h00, 1, 8'd2), 0);
        ticks(2);
        check(nmi, 1, "R6 write accepted while stopped");

        // R10: write and tick in the same cycle
        do_reset();
        step(1, word(7'h05, 1, 8'd2), 0);
        ticks(1);
        step(1, word(7'h7A, 1, 8'd2), 1);
        ticks(1);
        check(nmi, 0, "R10 coincident tick not counted");
        ticks(1);
        check(nmi, 1, "R10 reload from write");

        // Random phase against the bench model (R2 R3 R5 R7 R8 R10)
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            bit we, tk, good, run;
            bit [6:0] k;
            bit [7:0] c;
            we   = ($urandom_range(0, 7) == 0);
            tk   = ($urandom_range(0, 1) == 1);
            good = ($urandom_range(0, 9) < 7);
            run  = ($urandom_range(0, 9) < 8);
            k    = good ? ~m_key : 7'($urandom());
            c    = ($urandom_range(0, 49) == 0) ? 8'd0 : 8'($urandom_range(1, 6));
            step(we, word(k, run, c), tk);
            check(nmi, m_nmi, "R3/R8 random nmi");
            check(rr, m_rr, "R7 random reset_req");
            if (m_cnt > 100 && m_go) begin
                ticks(m_cnt);
                check(nmi, m_nmi, "R4 random long count");
            end
        end
        finish_run();
    end
endmodule